// File: doc/BRIEF.md
# Chainable Serial-Load Converter Input Stage

This block is the digital front end of a serially loaded digital-to-analog converter. A data word enters one bit at a time on `sdi`, most significant bit first, and moves into a shift register each time the combined strobe makes an active transition. As each new bit enters, the bit that has been in the register longest leaves on `sdo`. Devices can therefore be wired output-to-input in a chain that shares one data line, one strobe and one load line.

When a whole word is in place, the two active-low load inputs copy it into a holding register. That register drives the parallel code to the converter core. Because the load lines are separate from the shift path, every device in a chain can change its output on the same cycle. An asynchronous active-low clear forces the held code to zero and leaves the shift register untouched.

Strobes, loads and serial data go through two-flop synchronisers and are edge-detected against the free-running system clock `clk`.

Top module: `dac_serial_frontend`

## Requirements
- R1: The shift register is `CODE_W` bits wide (12 by default). After `CODE_W` shift events, the first bit entered sits at the most significant position, so a word sent MSB first appears unchanged on `dac_code` after a load.
- R2: `sdo` always shows the most significant bit of the shift register. Over `CODE_W` shift events, the previous word leaves on `sdo` MSB first, one bit per event.
- R3: A shift event is a rising edge of the combined strobe level. That level is high when any of `stb_rise[2:0]` is high or `stb_fall` is low. So a rise on any `stb_rise` bit, or a fall on `stb_fall`, shifts once, provided every other strobe is at its enabling level (`stb_rise` bits low, `stb_fall` high).
- R4: While any strobe is held away from its enabling level, transitions on the other strobes cause no shift.
- R5: While both `load_a_n` and `load_b_n` are low (after synchronisation), the holding register follows the shift register on every clock. While either is high, the holding register keeps its value.
- R6: Driving `clr_n` low sets `dac_code` to zero at once, without waiting for a clock edge. While `clr_n` is low, loads have no effect.
- R7: Clear does not change the shift register. A load after clear is released restores the word that was shifted in before the clear.
- R8: After reset, `dac_code` is zero and `sdo` is low.
- R9: Two devices chained `sdo` to `sdi`, sharing the strobe and load lines, act as one 2×`CODE_W`-bit shift register. A shared load updates both codes together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| sdi | input | 1 | Serial data in, MSB first |
| stb_rise | input | 3 | Strobes that act on a rising edge; enabling level low |
| stb_fall | input | 1 | Strobe that acts on a falling edge; enabling level high |
| load_a_n | input | 1 | Active-low load input A |
| load_b_n | input | 1 | Active-low load input B |
| clr_n | input | 1 | Active-low asynchronous clear of the holding register |
| sdo | output | 1 | Serial data out for chaining (shift register MSB) |
| dac_code | output | CODE_W | Held code for the converter core |

## Verification
Random 12-bit words are shifted in through each of the four strobes in turn. Every strobe then has to produce exactly one shift per active edge, and the bit order from MSB to LSB is confirmed on the loaded code. During each word, `sdo` is compared against the word that is leaving. This separates a correct MSB-out path from a reversed or shifted one. One load input at a time is held active to show that the load really requires both. Strobe activity while a blocking strobe is held is used to catch any combining rule other than the level-OR. Clear is asserted between clock edges and together with an active load, which shows that it acts asynchronously, that it wins over load, and that the shift register keeps its word. A second device chained to the first confirms that the two behave as one long register.

// File: rtl/dac_fe_pkg.sv
`timescale 1ns/1ps
package dac_fe_pkg;
    localparam int CODE_W_DEF   = 12;
    localparam int NUM_RISE_DEF = 3;

    // Bit slots of the synchroniser bundle
    function automatic int sync_width(input int num_rise);
        return num_rise + 4; // rise strobes, fall strobe, two loads, data
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
module dacfe_sync #(
    parameter int N = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stab;
        } sync_t;
        sync_t st_d, st_q;

        always_comb begin
            st_d.meta = d[g];
            st_d.stab = st_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '{meta: RST_VAL[g], stab: RST_VAL[g]};
            else        st_q <= st_d;
        end

        assign q[g] = st_q.stab;
    end
endmodule

// File: rtl/dacfe_strobe.sv
`timescale 1ns/1ps
module dacfe_strobe #(
    parameter int NUM_RISE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_RISE-1:0] rise_lvl,
    input  logic                fall_lvl,
    output logic                shift_evt
);
    typedef struct packed {
        logic prev;
    } stb_t;
    stb_t st_d, st_q;
    logic active_lvl;

    always_comb begin
        active_lvl = (|rise_lvl) | ~fall_lvl;
        st_d.prev  = active_lvl;
        shift_evt  = active_lvl & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    blocked_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active_lvl) && active_lvl) |-> !shift_evt);
endmodule

// File: rtl/dacfe_shreg.sv
`timescale 1ns/1ps
module dacfe_shreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    output logic [W-1:0] word,
    output logic         sdo
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] bits;
    } sr_t;
    sr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.bits = {st_q.bits[MSB-1:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.bits;
    assign sdo  = st_q.bits[MSB];

    // R1
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word == {$past(word[MSB-1:0]), $past(sdi)});
    // R7
    shreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shift_en) |-> $stable(word));
endmodule

// File: rtl/dacfe_hold.sv
`timescale 1ns/1ps
module dacfe_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load_en,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] code
);
    typedef struct packed {
        logic [W-1:0] code;
    } hold_t;
    hold_t st_d, st_q;
    logic  arst_n;

    assign arst_n = rst_n & clr_n;

    always_comb begin
        st_d = st_q;
        if (load_en) st_d.code = word_in;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign code = st_q.code;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> code == '0);
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(clr_n) && !$past(load_en)) |-> $stable(code));
endmodule

// File: rtl/dac_serial_frontend.sv
`timescale 1ns/1ps
module dac_serial_frontend #(
    parameter int CODE_W   = dac_fe_pkg::CODE_W_DEF,
    parameter int NUM_RISE = dac_fe_pkg::NUM_RISE_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic [NUM_RISE-1:0] stb_rise,
    input  logic                stb_fall,
    input  logic                load_a_n,
    input  logic                load_b_n,
    input  logic                clr_n,
    output logic                sdo,
    output logic [CODE_W-1:0]   dac_code
);
    localparam int SW       = dac_fe_pkg::sync_width(NUM_RISE);
    localparam int IDX_FALL = NUM_RISE;
    localparam int IDX_LA   = NUM_RISE + 1;
    localparam int IDX_LB   = NUM_RISE + 2;
    localparam int IDX_SDI  = NUM_RISE + 3;
    // idle levels: rise strobes low, fall strobe high, loads high, data low
    localparam logic [SW-1:0] SYNC_RST =
        (SW'(1) << IDX_FALL) | (SW'(1) << IDX_LA) | (SW'(1) << IDX_LB);

    logic [SW-1:0]     raw_in, synced;
    logic              shift_evt;
    logic              load_en;
    logic [CODE_W-1:0] word;

    assign raw_in = {sdi, load_b_n, load_a_n, stb_fall, stb_rise};

    dacfe_sync #(.N(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    dacfe_strobe #(.NUM_RISE(NUM_RISE)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_lvl  (synced[NUM_RISE-1:0]),
        .fall_lvl  (synced[IDX_FALL]),
        .shift_evt (shift_evt)
    );

    dacfe_shreg #(.W(CODE_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_evt),
        .sdi      (synced[IDX_SDI]),
        .word     (word),
        .sdo      (sdo)
    );

    assign load_en = ~synced[IDX_LA] & ~synced[IDX_LB];

    dacfe_hold #(.W(CODE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .load_en (load_en),
        .word_in (word),
        .code    (dac_code)
    );

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && clr_n) |=> (!clr_n || dac_code == $past(word)));
    // R2
    sdo_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |=> sdo == $past(word[CODE_W-2]));
endmodule

// File: tb/dac_serial_frontend_tb.sv
`timescale 1ns/1ps
module dac_serial_frontend_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdi = 1'b0;
    logic [2:0]   stb_rise = 3'b000;
    logic         stb_fall = 1'b1;
    logic         load_a_n = 1'b1;
    logic         load_b_n = 1'b1;
    logic         clr_n = 1'b1;
    logic         sdo, sdo_b;
    logic [W-1:0] code_a, code_b;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [W-1:0] m_a = '0, m_b = '0;

    always #2 clk = ~clk;

    dac_serial_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .stb_rise(stb_rise),
        .stb_fall(stb_fall), .load_a_n(load_a_n), .load_b_n(load_b_n),
        .clr_n(clr_n), .sdo(sdo), .dac_code(code_a)
    );

    dac_serial_frontend u_dut_b (
        .clk(clk), .rst_n(rst_n), .sdi(sdo), .stb_rise(stb_rise),
        .stb_fall(stb_fall), .load_a_n(load_a_n), .load_b_n(load_b_n),
        .clr_n(clr_n), .sdo(sdo_b), .dac_code(code_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] shift_model(input logic [W-1:0] cur, input logic b);
        return {cur[W-2:0], b};
    endfunction

    task automatic model_shift(input logic b);
        m_b = shift_model(m_b, m_a[W-1]);
        m_a = shift_model(m_a, b);
    endtask

    // sel 0..2: rising strobe, 3: falling strobe
    task automatic pulse(input int sel);
        if (sel < 3) stb_rise[sel] = 1'b1; else stb_fall = 1'b0;
        wait_cyc(5);
        if (sel < 3) stb_rise[sel] = 1'b0; else stb_fall = 1'b1;
        wait_cyc(5);
    endtask

    task automatic send_word(input logic [W-1:0] w, input int sel, input string req);
        for (int i = W - 1; i >= 0; i--) begin
            check("R2 sdo", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_a[W-1]});
            sdi = w[i];
            wait_cyc(4);
            pulse(sel);
            model_shift(w[i]);
        end
        check(req, {{(W-1){1'b0}}, sdo_b}, {{(W-1){1'b0}}, m_b[W-1]});
    endtask

    task automatic do_load();
        load_a_n = 1'b0; load_b_n = 1'b0;
        wait_cyc(6);
        load_a_n = 1'b1; load_b_n = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        logic [W-1:0] w, prev_code;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        // R8 reset state
        check("R8 code", code_a, '0);
        check("R8 sdo", {{(W-1){1'b0}}, sdo}, '0);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R8 code after release", code_a, '0);

        // R1 R3 directed words on every strobe
        send_word(12'h800, 0, "R1 single msb");
        do_load();
        check("R1 msb first", code_a, 12'h800);
        send_word(12'h001, 3, "R3 falling strobe");
        do_load();
        check("R3 fall strobe", code_a, 12'h001);
        check("R9 chained word", code_b, 12'h800);

        // random words through each strobe, with chained device
        for (int k = 0; k < 8; k++) begin
            w = W'($urandom());
            send_word(w, k % 4, "R9 chain sdo");
            do_load();
            check("R3 random word", code_a, m_a);
            check("R9 chained code", code_b, m_b);
        end

        // R5 only one load input active: no update
        prev_code = code_a;
        send_word(12'hA5C, 1, "R9 chain sdo");
        load_a_n = 1'b0; wait_cyc(8);
        check("R5 only A low", code_a, prev_code);
        load_a_n = 1'b1; load_b_n = 1'b0; wait_cyc(8);
        check("R5 only B low", code_a, prev_code);
        load_b_n = 1'b1; wait_cyc(4);
        do_load();
        check("R5 both low", code_a, 12'hA5C);

        // R4 blocking strobe: raising b is itself one shift, others then ignored
        sdi = 1'b1; wait_cyc(4);
        stb_rise[1] = 1'b1; wait_cyc(6);
        model_shift(1'b1);
        sdi = 1'b0; wait_cyc(4);
        pulse(0);
        pulse(2);
        pulse(3);
        stb_rise[1] = 1'b0; wait_cyc(6);
        do_load();
        check("R4 blocked strobes", code_a, m_a);
        check("R4 sdo after block", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_a[W-1]});

        // R6 async clear between edges
        @(negedge clk);
        clr_n = 1'b0;
        #0.5;
        check("R6 async clear", code_a, '0);
        // R6 clear wins over load
        load_a_n = 1'b0; load_b_n = 1'b0;
        wait_cyc(8);
        check("R6 clear over load", code_a, '0);
        check("R6 chained clear", code_b, '0);
        load_a_n = 1'b1; load_b_n = 1'b1;
        wait_cyc(6);
        clr_n = 1'b1;
        wait_cyc(4);
        check("R6 stays zero", code_a, '0);
        // R7 shift register kept
        check("R7 sdo kept", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_a[W-1]});
        do_load();
        check("R7 word kept", code_a, m_a);
        check("R7 chained word kept", code_b, m_b);

        // R2 final drain: previous word leaves MSB first
        send_word(12'h000, 2, "R2 drain");
        do_load();
        check("R2 drained", code_a, 12'h000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule